// File: doc/BRIEF.md
# Compare and Branch Condition Unit

This block evaluates one of six ordering or equality conditions between two 32-bit operands. It serves both the compare-to-register instructions of a 32-bit RISC datapath and its conditional branches. A single comparator drives two consumers:

- a 0/1 word that a compare instruction writes back to its destination register;
- a taken flag that steers the program counter.

Each condition can be evaluated on two's complement operands or on plain unsigned magnitudes.

In compare-immediate use, the second operand is replaced by a 16-bit immediate. That immediate is sign-extended for signed compares and zero-extended for unsigned ones. In branch use, the same 16-bit field is a signed displacement added to the next sequential address. A program counter register holds the current address. It loads the resolved next address on each enabled clock edge and clears on a synchronous reset.

Top module: `cmpbr_unit`

## Requirements
- R1: The `cond` input selects the condition by code: 0 equal, 1 not equal, 2 less than, 3 greater or equal, 4 greater than, 5 less or equal. Codes 6 and 7 are invalid.
- R2: With `is_unsigned` = 0, both operands are ordered as two's complement numbers, so 0x80000000 is less than 0x7FFFFFFF.
- R3: With `is_unsigned` = 1, both operands are ordered as unsigned magnitudes, so 0x7FFFFFFF is less than 0x80000000.
- R4: `cmp_result` is 1 when the selected condition holds and 0 otherwise. Bits 31..1 are always 0.
- R5: With `use_imm` = 1 and `is_branch` = 0, the second compare operand is `imm16` sign-extended to 32 bits in signed mode, or zero-extended in unsigned mode. In that case `opb` has no effect.
- R6: With `is_branch` = 1, `opa` is compared with `opb` whatever the value of `use_imm`, and `br_taken` equals the outcome of the condition. With `is_branch` = 0, `br_taken` is 0.
- R7: `pc_next` equals `pc` + 4 + sign-extended `imm16` when `br_taken` is 1, and `pc` + 4 otherwise, modulo 2^32.
- R8: On a rising clock edge with `en` = 1, `pc` takes the value `pc_next` had before the edge. With `en` = 0, `pc` keeps its value.
- R9: A synchronous active-high `rst` sets `pc` to 0 at the next rising edge, whatever the value of `en`.
- R10: An invalid condition code gives `cmp_result` = 0, `br_taken` = 0 and `pc_next` = `pc` + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| en | input | 1 | Program counter update enable |
| opa | input | 32 | First compare operand |
| opb | input | 32 | Second compare operand (register form) |
| imm16 | input | 16 | Compare immediate or branch displacement |
| cond | input | 3 | Condition code |
| is_unsigned | input | 1 | 1 selects unsigned ordering |
| use_imm | input | 1 | 1 selects the immediate as second compare operand |
| is_branch | input | 1 | 1 marks a conditional branch |
| cmp_result | output | 32 | 0/1 compare outcome for register write-back |
| br_taken | output | 1 | Branch taken flag |
| pc_next | output | 32 | Resolved next program counter |
| pc | output | 32 | Current program counter |

## Verification
In a branch cycle, the comparator output feeds the compare result word and the taken flag, while the program counter is committing the previous cycle's target. A wrong condition therefore shows up in two places, and one of them only after the clock edge. The bench provokes this by issuing back-to-back branches with negative and positive displacements on operand pairs such as 0x7FFFFFFF against 0x80000000, where the signed and unsigned orderings disagree. It interleaves these with compare-immediate cycles in which `opb` carries a value that would flip the outcome. A behavioural model predicts the compare word, the taken flag and the next address in every cycle, and the committed PC one edge later.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

    localparam int CMPBR_XLEN    = 32;
    localparam int CMPBR_IMM_W   = 16;
    localparam int CMPBR_COND_W  = 3;

    // condition codes; 6 and 7 are left unassigned and treated as invalid
    typedef enum logic [CMPBR_COND_W-1:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_LT = 3'd2,
        CC_GE = 3'd3,
        CC_GT = 3'd4,
        CC_LE = 3'd5
    } cond_e;

    typedef struct packed {
        logic valid;   // condition code is one of the six defined ones
        logic holds;   // condition is true for the current operands
    } cmp_flags_t;

    // 1 when code names a defined condition
    function automatic logic cond_is_valid(input logic [CMPBR_COND_W-1:0] code);
        return (code <= 3'd5);
    endfunction

endpackage

// File: rtl/cmpbr_operand_sel.sv
module cmpbr_operand_sel
    import cmpbr_pkg::*;
#(
    parameter int XLEN  = CMPBR_XLEN,
    parameter int IMM_W = CMPBR_IMM_W
) (
    input  logic [XLEN-1:0]  opb,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             is_branch,
    input  logic             is_unsigned,
    output logic [XLEN-1:0]  opb_eff,
    output logic [XLEN-1:0]  disp
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_zext;
    logic [XLEN-1:0] imm_sext;

    always_comb begin
        imm_zext = {{PAD_W{1'b0}}, imm};
        imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
    end

    // a branch always compares two registers; the immediate is its displacement
    always_comb begin
        if (use_imm && !is_branch) begin
            opb_eff = is_unsigned ? imm_zext : imm_sext;
        end else begin
            opb_eff = opb;
        end
        disp = imm_sext;
    end
endmodule

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval
    import cmpbr_pkg::*;
#(
    parameter int XLEN = CMPBR_XLEN
) (
    input  logic [XLEN-1:0]         a,
    input  logic [XLEN-1:0]         b,
    input  logic [CMPBR_COND_W-1:0] cond,
    input  logic                    is_unsigned,
    output cmp_flags_t              flags
);
    // one extra top bit turns both orderings into a single signed compare
    localparam int EXT_W = XLEN + 1;

    logic [EXT_W-1:0] a_x;
    logic [EXT_W-1:0] b_x;
    logic             eq;
    logic             lt;

    always_comb begin
        a_x = {(is_unsigned ? 1'b0 : a[XLEN-1]), a};
        b_x = {(is_unsigned ? 1'b0 : b[XLEN-1]), b};
        eq  = (a == b);
        lt  = ($signed(a_x) < $signed(b_x));
    end

    always_comb begin
        flags.valid = cond_is_valid(cond);
        case (cond_e'(cond))
            CC_EQ:   flags.holds = eq;
            CC_NE:   flags.holds = !eq;
            CC_LT:   flags.holds = lt;
            CC_GE:   flags.holds = !lt;
            CC_GT:   flags.holds = !lt && !eq;
            CC_LE:   flags.holds = lt || eq;
            default: flags.holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpbr_pc_stage.sv
module cmpbr_pc_stage
    import cmpbr_pkg::*;
#(
    parameter int          XLEN     = CMPBR_XLEN,
    parameter int          PC_STEP  = 4,
    parameter logic [31:0] PC_RESET = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            taken,
    input  logic [XLEN-1:0] disp,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_nxt
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);
    localparam logic [XLEN-1:0] RVAL = XLEN'(PC_RESET);

    logic [XLEN-1:0] seq_pc;

    always_comb begin
        seq_pc = pc_q + STEP;
        pc_nxt = taken ? (seq_pc + disp) : seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RVAL;
        end else if (en) begin
            pc_q <= pc_nxt;
        end
    end
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
    import cmpbr_pkg::*;
#(
    parameter int XLEN    = CMPBR_XLEN,
    parameter int IMM_W   = CMPBR_IMM_W,
    parameter int PC_STEP = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [XLEN-1:0]         opa,
    input  logic [XLEN-1:0]         opb,
    input  logic [IMM_W-1:0]        imm16,
    input  logic [CMPBR_COND_W-1:0] cond,
    input  logic                    is_unsigned,
    input  logic                    use_imm,
    input  logic                    is_branch,
    output logic [XLEN-1:0]         cmp_result,
    output logic                    br_taken,
    output logic [XLEN-1:0]         pc_next,
    output logic [XLEN-1:0]         pc
);
    logic [XLEN-1:0] opb_eff;
    logic [XLEN-1:0] disp;
    cmp_flags_t      flags;
    logic            cond_true;

    cmpbr_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
        .opb        (opb),
        .imm        (imm16),
        .use_imm    (use_imm),
        .is_branch  (is_branch),
        .is_unsigned(is_unsigned),
        .opb_eff    (opb_eff),
        .disp       (disp)
    );

    cmpbr_cond_eval #(.XLEN(XLEN)) u_eval (
        .a          (opa),
        .b          (opb_eff),
        .cond       (cond),
        .is_unsigned(is_unsigned),
        .flags      (flags)
    );

    always_comb begin
        cond_true  = flags.valid && flags.holds;
        cmp_result = {{(XLEN-1){1'b0}}, cond_true};
        br_taken   = is_branch && cond_true;
    end

    cmpbr_pc_stage #(.XLEN(XLEN), .PC_STEP(PC_STEP), .PC_RESET(32'h0)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .taken (br_taken),
        .disp  (disp),
        .pc_q  (pc),
        .pc_nxt(pc_next)
    );
endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [2:0]      cond,
    input logic            is_branch,
    input logic [XLEN-1:0] cmp_result,
    input logic            br_taken,
    input logic [XLEN-1:0] pc_next,
    input logic [XLEN-1:0] pc
);
    // R4
    result_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_result[XLEN-1:1] == '0);

    // R6
    no_take_outside_branch_chk: assert property (@(posedge clk) disable iff (rst)
        !is_branch |-> !br_taken);

    // R6
    take_matches_result_chk: assert property (@(posedge clk) disable iff (rst)
        is_branch |-> (br_taken == cmp_result[0]));

    // R10
    invalid_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cond > 3'd5) |-> (!br_taken && cmp_result == '0 && pc_next == pc + XLEN'(4)));

    // R7
    fallthrough_step_chk: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (pc_next == pc + XLEN'(4)));

    // R8
    pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (pc == $past(pc_next)));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc));

    // R9
    pc_reset_chk: assert property (@(posedge clk)
        rst |=> (pc == '0));
endmodule

bind cmpbr_unit cmpbr_unit_chk #(.XLEN(XLEN)) u_cmpbr_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cond      (cond),
    .is_branch (is_branch),
    .cmp_result(cmp_result),
    .br_taken  (br_taken),
    .pc_next   (pc_next),
    .pc        (pc)
);

// File: tb/cmpbr_unit_bench.sv
`timescale 1ns/1ps
module cmpbr_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [15:0] imm16 = '0;
    logic [2:0]  cond = '0;
    logic        is_unsigned = 1'b0;
    logic        use_imm = 1'b0;
    logic        is_branch = 1'b0;
    logic [31:0] cmp_result;
    logic        br_taken;
    logic [31:0] pc_next;
    logic [31:0] pc;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [31:0] model_pc = '0;

    always #2.5 clk = ~clk;

    cmpbr_unit u_cmpbr_unit (
        .clk(clk), .rst(rst), .en(en), .opa(opa), .opb(opb), .imm16(imm16),
        .cond(cond), .is_unsigned(is_unsigned), .use_imm(use_imm),
        .is_branch(is_branch), .cmp_result(cmp_result), .br_taken(br_taken),
        .pc_next(pc_next), .pc(pc)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // behavioural reference: widen to 64-bit signed integers and compare
    function automatic bit ref_holds(input int code, input bit uns,
                                     input logic [31:0] a, input logic [31:0] b);
        longint x, y;
        x = uns ? longint'({32'h0, a}) : longint'($signed(a));
        y = uns ? longint'({32'h0, b}) : longint'($signed(b));
        case (code)
            0: return x == y;
            1: return x != y;
            2: return x <  y;
            3: return x >= y;
            4: return x >  y;
            5: return x <= y;
            default: return 1'b0;
        endcase
    endfunction

    // one cycle: drive at falling edge, check combinational outputs, then the edge
    task automatic step(input string req, input bit e, input bit r,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                        input int code, input bit uns, input bit ui, input bit br);
        logic [31:0] b_eff;
        bit          h;
        bit          tk;
        logic [31:0] nxt;
        @(negedge clk);
        en = e; rst = r; opa = a; opb = b; imm16 = im;
        cond = 3'(code); is_unsigned = uns; use_imm = ui; is_branch = br;
        #1;
        if (ui && !br) b_eff = uns ? {16'h0, im} : {{16{im[15]}}, im};
        else           b_eff = b;
        h   = ref_holds(code, uns, a, b_eff);
        tk  = br && h;
        nxt = model_pc + 32'd4 + (tk ? {{16{im[15]}}, im} : 32'd0);
        if (!r) begin
            check32(req, "cmp_result", cmp_result, {31'h0, h});
            check32(req, "br_taken", {31'h0, br_taken}, {31'h0, tk});
            check32(req, "pc_next", pc_next, nxt);
        end
        if (r)      model_pc = 32'h0;
        else if (e) model_pc = nxt;
        @(posedge clk);
        #1;
        check32(r ? "R9" : "R8", "pc", pc, model_pc);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] pairs [8];
        pairs[0] = 32'h7FFFFFFF; pairs[1] = 32'h80000000;
        pairs[2] = 32'h00000000; pairs[3] = 32'hFFFFFFFF;
        pairs[4] = 32'h00000005; pairs[5] = 32'h00000005;
        pairs[6] = 32'h80000000; pairs[7] = 32'h80000001;

        // R9: reset state, reset overrides enable
        step("R9", 1'b1, 1'b1, '0, '0, '0, 0, 0, 0, 0);
        step("R9", 1'b0, 1'b1, '0, '0, '0, 0, 0, 0, 0);

        // R1 R2 R3 R4: every code, both orderings, boundary pairs both ways
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int u = 0; u < 2; u++) begin
                    step(u ? "R3" : "R2", 1'b1, 1'b0, pairs[2*p], pairs[2*p+1], 16'h1234,
                         c, u[0], 0, 0);
                    step("R1", 1'b1, 1'b0, pairs[2*p+1], pairs[2*p], 16'h1234,
                         c, u[0], 0, 0);
                end
            end
        end

        // R5: immediate operand, opb set to flip the outcome if it leaked in
        for (int c = 0; c < 6; c++) begin
            step("R5", 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, c, 0, 1, 0);
            step("R5", 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, c, 1, 1, 0);
            step("R5", 1'b1, 1'b0, 32'h00008000, 32'h00008000, 16'h8000, c, 1, 1, 0);
            step("R5", 1'b1, 1'b0, 32'hFFFF8000, 32'h00000000, 16'h8000, c, 0, 1, 0);
        end

        // R6 R7: branches, back to back, negative and positive displacements
        step("R7", 1'b1, 1'b0, 32'h7FFFFFFF, 32'h80000000, 16'hFFF8, 2, 1, 0, 1);
        step("R7", 1'b1, 1'b0, 32'h7FFFFFFF, 32'h80000000, 16'hFFF8, 2, 0, 0, 1);
        step("R6", 1'b1, 1'b0, 32'h00000003, 32'h00000003, 16'h0100, 0, 0, 1, 1);
        step("R7", 1'b1, 1'b0, 32'h00000001, 32'h00000002, 16'h7FFC, 5, 0, 0, 1);
        step("R7", 1'b1, 1'b0, 32'h00000001, 32'h00000002, 16'h8000, 3, 1, 0, 1);
        step("R6", 1'b1, 1'b0, 32'h00000001, 32'h00000002, 16'h0040, 1, 0, 0, 0);

        // R10: invalid codes never take or report true
        step("R10", 1'b1, 1'b0, 32'h1, 32'h1, 16'h0010, 6, 0, 0, 1);
        step("R10", 1'b1, 1'b0, 32'h1, 32'h2, 16'h0010, 7, 1, 0, 1);

        // R8: hold with enable low while a branch would be taken
        step("R8", 1'b0, 1'b0, 32'h5, 32'h5, 16'h0020, 0, 0, 0, 1);
        step("R8", 1'b0, 1'b0, 32'h5, 32'h6, 16'h0020, 1, 0, 0, 1);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            step("R6", ($urandom % 4) != 0, 1'b0, $urandom, $urandom, 16'($urandom),
                 int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R9: reset again mid-run
        step("R9", 1'b1, 1'b1, '0, '0, '0, 0, 0, 0, 0);
        step("R8", 1'b1, 1'b0, 32'h0, 32'h0, 16'h0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule